// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block sits beside the fetch unit of a processor core and turns exception requests into control transfers. Each cause raises a one-cycle request that is latched as pending. A fixed-priority arbiter picks one eligible cause. The sequencer then performs the entry in one cycle:

- it saves a return address into the first save/restore register (SRR0);
- it builds the second save/restore register (SRR1) from preserved machine state bits and cause-specific status;
- it clears the relocation and user-mode bits of the machine state register (MSR);
- it emits a vector fetch address.

A return request performs the reverse. SRR1 is copied back into the MSR, and fetch is redirected to SRR0.

The controller has two states. S_RUN is the normal state, in which entries, returns and MSR writes happen. S_STOP is the checkstop state. The only transition is `halt`, from S_RUN to S_STOP, taken when a machine check wins arbitration while the machine-check enable bit is clear. S_STOP has no exit other than reset.

Bit numbers below are big-endian (bit 0 is the MSR's most significant bit). The little-endian position in the 32-bit vector is given in brackets.

Top module: `exc_seq`

## Requirements
- R1: After reset:
  - `msr` is 0x0000_1040 (ME = BE19 [12] and IP = BE25 [6] set);
  - `srr0` and `srr1` are zero;
  - `fetch_vld` and `checkstop` are low.
- R2: On entry, `fetch_addr` is the base ORed with a 256-byte-spaced offset. The base is 0xFFF0_0000 when MSR IP (BE25 [6]) is 1 and zero when it is 0. The offsets are:
  - system reset 0x100, machine check 0x200;
  - data storage 0x300, instruction storage 0x400;
  - external 0x500, decrementer 0x900, system call 0xC00.
- R3: On entry, SRR1 receives the MSR bits BE0, BE5..BE9 and BE16..BE31 in place (little-endian mask 0x87C0_FFFF). All other SRR1 bits hold the cause field.
- R4: For an instruction-storage entry, `isi_st[0]` sets SRR1 BE1 [30], `isi_st[1]` sets BE3 [28], `isi_st[2]` sets BE4 [27] and `isi_st[3]` sets BE10 [21]. `isi_st` is latched with the request. For every other cause the cause field is zero and `isi_st` has no effect.
- R5: SRR0 receives `next_pc` for system reset, system call, external and decrementer. It receives `cur_pc` for machine check, instruction storage and data storage.
- R6: On entry, the new MSR equals the old MSR with PR (BE17 [14]), IR (BE26 [5]) and DR (BE27 [4]) cleared. No other bit changes.
- R7: External and decrementer requests stay pending while MSR EE (BE16 [15]) is 0. They are taken at the first edge at which EE is 1. System reset and machine check ignore EE.
- R8: The priority from highest to lowest is: system reset, machine check, instruction storage, data storage, system call, external, decrementer. Among simultaneous eligible requests, the highest wins.
- R9: An ordered cause (every cause except system reset and machine check) is taken only if it ranks above the cause last entered. A return clears that record. System reset and machine check are never blocked by it.
- R10: `exc_req` is captured at one clock edge, and the entry happens at the next edge. At that edge:
  - `fetch_vld` pulses for one cycle;
  - the pending bit of the taken cause clears.
- R11: A machine check selected while ME (BE19 [12]) is 0 moves the block to S_STOP. In S_STOP, `checkstop` is 1 and no vector is produced. Nothing further is taken until reset.
- R12: When no entry happens at the same edge, `rfi` loads the MSR from SRR1 at the next edge, with `fetch_addr` equal to SRR0 and `fetch_vld` high.
- R13: When neither an entry nor a return happens at the same edge, `msr_we` loads `msr_wdata` into the MSR at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| exc_req | input | 7 | One-cycle requests. Bit 0 system reset, 1 machine check, 2 instr storage, 3 data storage, 4 system call, 5 external, 6 decrementer |
| isi_st | input | 4 | Instruction-storage fault status, latched with its request |
| cur_pc | input | 32 | Address of the current or faulting instruction |
| next_pc | input | 32 | Address of the instruction that would execute next |
| rfi | input | 1 | Return-from-interrupt request |
| msr_we | input | 1 | MSR write enable |
| msr_wdata | input | 32 | MSR write data |
| fetch_vld | output | 1 | Fetch redirect pulse |
| fetch_addr | output | 32 | Redirect address (vector or return address) |
| msr | output | 32 | Machine state register |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 32 | Saved state and cause field |
| checkstop | output | 1 | Sticky checkstop flag |

## Verification
Random single-cause entries use random MSR contents, program counters and storage status. Each entry is followed by a return. This separates the per-cause vector offset and SRR0 source, the SRR1 merge with its ISI-only cause field, and the IP-selected base.

Directed cases cover several further situations:
- A request held back by EE and then released by an MSR write, which tells masking apart from loss.
- A simultaneous burst of three causes, which exposes the priority order.
- A nested entry, which exposes the in-service ordering rule and its clearing on return.
- A machine check with ME clear, which shows that the checkstop is sticky and that later requests are refused.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN   = 32;
    localparam int NCAUSE = 7;
    localparam int CW     = 3;

    // cause indices, lower index = higher priority
    localparam logic [CW-1:0] C_RST = 3'd0;
    localparam logic [CW-1:0] C_MCK = 3'd1;
    localparam logic [CW-1:0] C_ISI = 3'd2;
    localparam logic [CW-1:0] C_DSI = 3'd3;
    localparam logic [CW-1:0] C_SC  = 3'd4;
    localparam logic [CW-1:0] C_EXT = 3'd5;
    localparam logic [CW-1:0] C_DEC = 3'd6;
    localparam logic [CW-1:0] SVC_NONE = 3'd7;

    localparam int ORD_FIRST  = 2;  // first ordered cause
    localparam int MASK_FIRST = 5;  // first EE-gated cause

    // little-endian positions of big-endian MSR bits
    localparam int B_EE = XLEN - 1 - 16;
    localparam int B_PR = XLEN - 1 - 17;
    localparam int B_ME = XLEN - 1 - 19;
    localparam int B_IP = XLEN - 1 - 25;
    localparam int B_IR = XLEN - 1 - 26;
    localparam int B_DR = XLEN - 1 - 27;

    function automatic logic [XLEN-1:0] keep_mask();
        logic [XLEN-1:0] m;
        m = '0;
        for (int be = 0; be < XLEN; be++) begin
            if (be == 0 || (be >= 5 && be <= 9) || be >= 16)
                m[XLEN-1-be] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [11:0] vec_off(logic [CW-1:0] c);
        logic [11:0] o;
        case (c)
            C_RST:   o = 12'h100;
            C_MCK:   o = 12'h200;
            C_DSI:   o = 12'h300;
            C_ISI:   o = 12'h400;
            C_EXT:   o = 12'h500;
            C_DEC:   o = 12'h900;
            default: o = 12'hC00;
        endcase
        return o;
    endfunction
endpackage

// File: rtl/exc_arb.sv
module exc_arb
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] pend,
    input  logic              ee,
    input  logic [CW-1:0]     svc,
    output logic              any,
    output logic [CW-1:0]     idx,
    output logic [NCAUSE-1:0] grant
);
    logic [NCAUSE-1:0] elig;

    for (genvar i = 0; i < NCAUSE; i++) begin : g_elig
        if (i < ORD_FIRST) begin : g_unord
            assign elig[i] = pend[i];
        end else if (i < MASK_FIRST) begin : g_ord
            assign elig[i] = pend[i] && (CW'(i) < svc);
        end else begin : g_mask
            assign elig[i] = pend[i] && (CW'(i) < svc) && ee;
        end
    end

    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any   = 1'b1;
                idx   = CW'(i);
                grant = NCAUSE'(1) << i;
            end
        end
    end

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (grant != '0)));

    // R7
    ee_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[C_EXT] || grant[C_DEC]) |-> ee);
endmodule

// File: rtl/exc_srr1.sv
module exc_srr1
    import exc_pkg::*;
(
    input  logic [XLEN-1:0] msr_in,
    input  logic [CW-1:0]   cause,
    input  logic [3:0]      isi_st,
    output logic [XLEN-1:0] srr1_out
);
    localparam logic [XLEN-1:0] KEEP = keep_mask();

    logic [XLEN-1:0] info;

    always_comb begin
        info = '0;
        if (cause == C_ISI) begin
            info[XLEN-1-1]  = isi_st[0];
            info[XLEN-1-3]  = isi_st[1];
            info[XLEN-1-4]  = isi_st[2];
            info[XLEN-1-10] = isi_st[3];
        end
        srr1_out = (msr_in & KEEP) | (info & ~KEEP);
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import exc_pkg::*;
#(
    parameter logic [31:0] HI_BASE = 32'hFFF0_0000,
    parameter logic [31:0] MSR_RST = 32'h0000_1040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] exc_req,
    input  logic [3:0]        isi_st,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic              rfi,
    input  logic              msr_we,
    input  logic [XLEN-1:0]   msr_wdata,
    output logic              fetch_vld,
    output logic [XLEN-1:0]   fetch_addr,
    output logic [XLEN-1:0]   msr,
    output logic [XLEN-1:0]   srr0,
    output logic [XLEN-1:0]   srr1,
    output logic              checkstop
);
    typedef enum logic {S_RUN, S_STOP} st_e;

    localparam logic [XLEN-1:0] CLR_ON_ENTRY =
        (XLEN'(1) << B_PR) | (XLEN'(1) << B_IR) | (XLEN'(1) << B_DR);

    st_e               st_q, st_n;
    logic [NCAUSE-1:0] pend_q, grant;
    logic              any;
    logic [CW-1:0]     idx, svc_q;
    logic [3:0]        isi_q;
    logic              halt, take, ret;
    logic              vec_q;
    logic [XLEN-1:0]   srr1_new, srr0_new, vec_addr;

    exc_arb u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .pend (pend_q),
        .ee   (msr[B_EE]),
        .svc  (svc_q),
        .any  (any),
        .idx  (idx),
        .grant(grant)
    );

    exc_srr1 u_srr1 (
        .msr_in  (msr),
        .cause   (idx),
        .isi_st  (isi_q),
        .srr1_out(srr1_new)
    );

    always_comb begin
        halt     = (st_q == S_RUN) && any && (idx == C_MCK) && !msr[B_ME];
        take     = (st_q == S_RUN) && any && !halt;
        ret      = (st_q == S_RUN) && !any && rfi;
        vec_addr = (msr[B_IP] ? HI_BASE : '0) | {{(XLEN-12){1'b0}}, vec_off(idx)};
        case (idx)
            C_RST, C_SC, C_EXT, C_DEC: srr0_new = next_pc;
            default:                   srr0_new = cur_pc;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_RUN;
        else        st_q <= st_n;
    end

    // next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            S_RUN:  if (halt) st_n = S_STOP;
            S_STOP: st_n = S_STOP;
        endcase
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= '0;
            isi_q      <= '0;
            svc_q      <= SVC_NONE;
            msr        <= MSR_RST;
            srr0       <= '0;
            srr1       <= '0;
            fetch_vld  <= 1'b0;
            fetch_addr <= '0;
            vec_q      <= 1'b0;
        end else begin
            pend_q    <= (pend_q & ~(take ? grant : '0)) | exc_req;
            fetch_vld <= take || ret;
            vec_q     <= take;
            if (exc_req[C_ISI]) isi_q <= isi_st;
            if (take) begin
                srr0       <= srr0_new;
                srr1       <= srr1_new;
                msr        <= msr & ~CLR_ON_ENTRY;
                fetch_addr <= vec_addr;
                svc_q      <= idx;
            end else if (ret) begin
                msr        <= srr1;
                fetch_addr <= srr0;
                svc_q      <= SVC_NONE;
            end else if (st_q == S_RUN && msr_we) begin
                msr <= msr_wdata;
            end
        end
    end

    assign checkstop = (st_q == S_STOP);

    // R11
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |=> checkstop);

    // R11
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_STOP) |=> !fetch_vld);

    // R2
    vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_q |-> (fetch_addr[7:0] == 8'h00) && fetch_vld);

    // R10
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ((exc_req & grant) == '0)) |=> ((pend_q & $past(grant)) == '0));

    // R12
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret |=> (msr == $past(srr1)) && (fetch_addr == $past(srr0)));
endmodule

// File: tb/exc_seq_tb.sv
module exc_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  exc_req = '0;
    logic [3:0]  isi_st = '0;
    logic [31:0] cur_pc = '0, next_pc = '0, msr_wdata = '0;
    logic        rfi = 1'b0, msr_we = 1'b0;
    logic        fetch_vld, checkstop;
    logic [31:0] fetch_addr, msr, srr0, srr1;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam logic [31:0] EE = 32'h0000_8000;
    localparam logic [31:0] ME = 32'h0000_1000;
    localparam logic [31:0] IP = 32'h0000_0040;

    always #10 clk = ~clk;

    exc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .isi_st(isi_st),
        .cur_pc(cur_pc), .next_pc(next_pc), .rfi(rfi), .msr_we(msr_we),
        .msr_wdata(msr_wdata), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
        .msr(msr), .srr0(srr0), .srr1(srr1), .checkstop(checkstop)
    );

    function automatic logic [31:0] exp_vec(int c, logic [31:0] m);
        logic [31:0] o;
        case (c)
            0: o = 32'h100; 1: o = 32'h200; 2: o = 32'h400; 3: o = 32'h300;
            4: o = 32'hC00; 5: o = 32'h500; default: o = 32'h900;
        endcase
        return (m[6] ? 32'hFFF0_0000 : 32'h0) | o;
    endfunction

    function automatic logic [31:0] exp_srr1(int c, logic [31:0] m, logic [3:0] st);
        logic [31:0] r;
        r = m & 32'h87C0_FFFF;
        if (c == 2) r = r | {1'b0, st[0], 1'b0, st[1], st[2], 5'b0, st[3], 21'b0};
        return r;
    endfunction

    function automatic logic [31:0] exp_srr0(int c, logic [31:0] cp, logic [31:0] np);
        return (c == 0 || c == 4 || c == 5 || c == 6) ? np : cp;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_msr(logic [31:0] v);
        @(negedge clk); msr_we = 1'b1; msr_wdata = v;
        @(negedge clk); msr_we = 1'b0;
    endtask

    task automatic pulse_req(logic [6:0] r);
        @(negedge clk); exc_req = r;
        @(negedge clk); exc_req = '0;
    endtask

    // entry of a single eligible cause and its check
    task automatic take_one(int c, logic [31:0] m, logic [3:0] st);
        cur_pc = $urandom & 32'hFFFF_FFFC;
        next_pc = $urandom & 32'hFFFF_FFFC;
        isi_st = st;
        pulse_req(7'(1) << c);
        isi_st = ~st;
        @(negedge clk);
        chk("R10 fetch_vld", 32'(fetch_vld), 1);
        chk("R2 vector", fetch_addr, exp_vec(c, m));
        chk("R5 srr0", srr0, exp_srr0(c, cur_pc, next_pc));
        chk("R3/R4 srr1", srr1, exp_srr1(c, m, st));
        chk("R6 msr", msr, m & ~32'h0000_4030);
    endtask

    task automatic do_rfi();
        logic [31:0] s0, s1;
        s0 = srr0; s1 = srr1;
        @(negedge clk); rfi = 1'b1;
        @(negedge clk); rfi = 1'b0;
        chk("R12 msr", msr, s1);
        chk("R12 fetch", fetch_addr, s0);
        chk("R12 vld", 32'(fetch_vld), 1);
    endtask

    task automatic expect_idle(string tag, int n);
        logic [31:0] s0;
        s0 = srr0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(tag, 32'(fetch_vld), 0);
        end
        chk(tag, srr0, s0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] m;
        int c;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        // R1
        chk("R1 msr", msr, 32'h0000_1040);
        chk("R1 srr0", srr0, 0);
        chk("R1 srr1", srr1, 0);
        chk("R1 flags", {30'b0, fetch_vld, checkstop}, 0);
        rst_n = 1'b1;

        // random single causes with return
        for (int it = 0; it < 60; it++) begin
            c = int'($urandom_range(0, 6));
            m = $urandom | ME;
            if (c >= 5) m = m | EE;
            wr_msr(m);
            take_one(c, m, 4'($urandom));
            do_rfi();
        end

        // R13 write
        wr_msr(ME);
        chk("R13 msr write", msr, ME);

        // R7 EE gating: external held, then released
        next_pc = 32'h0000_4440;
        pulse_req(7'b010_0000);
        expect_idle("R7 masked", 3);
        wr_msr(ME | EE);
        @(negedge clk);
        chk("R7 released vld", 32'(fetch_vld), 1);
        chk("R7 released vec", fetch_addr, 32'h500);
        chk("R7 srr0", srr0, 32'h0000_4440);
        do_rfi();

        // R8 priority burst, R9 ordering
        wr_msr(ME | EE);
        pulse_req(7'b110_0001);
        @(negedge clk);
        chk("R8 reset first", fetch_addr, 32'h100);
        expect_idle("R9 blocked after reset", 2);
        do_rfi();
        @(negedge clk);
        chk("R8 external second", fetch_addr, 32'h500);
        chk("R8 vld", 32'(fetch_vld), 1);
        do_rfi();
        @(negedge clk);
        chk("R8 decrementer third", fetch_addr, 32'h900);
        do_rfi();

        // R9 nesting
        wr_msr(ME | EE);
        take_one(5, ME | EE, 4'h0);
        pulse_req(7'b000_0100);
        @(negedge clk);
        chk("R9 higher nests", fetch_addr, 32'h400);
        pulse_req(7'b100_0000);
        expect_idle("R9 lower blocked", 3);
        do_rfi();
        @(negedge clk);
        chk("R9 after return", fetch_addr, 32'h900);
        do_rfi();

        // R2 high base with system call
        wr_msr(ME | IP);
        take_one(4, ME | IP, 4'hF);
        do_rfi();

        // R11 checkstop
        wr_msr(32'h0);
        pulse_req(7'b000_0010);
        @(negedge clk);
        chk("R11 checkstop", 32'(checkstop), 1);
        chk("R11 no vector", 32'(fetch_vld), 0);
        pulse_req(7'b000_0001);
        expect_idle("R11 refuses reset", 3);
        chk("R11 sticky", 32'(checkstop), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 checkstop clear", 32'(checkstop), 0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1;
        $finish;
    end
endmodule